// File: doc/BRIEF.md
# Slow-Memory ADC Read Controller

This block sits on the host side of a 14-bit sampling converter whose conversion is started by the read access itself. When a request arrives, the controller drops chip-select and the read strobe together while the byte-select line is low. That falling chip-select edge puts the converter's sampler into hold and starts a conversion. The converter then pulls its active-low busy line down. The controller stalls the access, the way a wait-stated memory read stalls, until busy returns high. After a fixed strobe-to-data delay it latches the data lines and hands the 14-bit result back with a one-cycle valid pulse.

In parallel mode, one strobe fetches all 14 bits. In byte mode, the first access must fetch the low byte, because byte-select has to be low to start a conversion. Both lines are then released for a minimum gap. A second, ordinary access follows with byte-select high and no busy wait, and it returns bits 13..8 on data lines 5..0. A timeout aborts the access if busy does not come back within a set number of clocks.

States: `ST_IDLE`, `ST_ARM` (chip-select low, waiting for busy to fall), `ST_CONV` (waiting for busy to rise), `ST_LORD` (strobe delay and capture of the first access), `ST_GAP` (lines released), `ST_HIRD` (high-byte access), `ST_DONE` and `ST_FAIL`.

Transitions:
- IDLE→ARM on an accepted request.
- ARM→CONV when busy is low.
- CONV→LORD when busy is high.
- ARM or CONV→FAIL when the timeout count is reached.
- LORD→DONE in parallel mode, or LORD→GAP in byte mode, after `RD_DLY` clocks.
- GAP→HIRD after `GAP_CLKS` clocks.
- HIRD→DONE after `RD_DLY` clocks.
- DONE→IDLE and FAIL→IDLE unconditionally.

Top module: `adc_rd_ctrl`

## Requirements
- R1: Out of reset, `adc_cs_n_o` and `adc_rd_n_o` are 1, `adc_hben_o` is 0, `rsp_valid_o` and `rsp_err_o` are 0, and `req_rdy_o` is 1.
- R2: An access starts with chip-select and the read strobe falling together while `adc_hben_o` is 0. A parallel-mode transaction contains exactly one chip-select fall.
- R3: The data lines are not latched until `adc_busy_n_i` has gone low and then returned high after the chip-select fall.
- R4: Data is latched only after the read strobe has been low for `RD_DLY` clocks with busy high.
- R5: In parallel mode (`mode_byte_i`=0), `rsp_data_o[13:0]` equals `adc_db_i[13:0]` from the single access.
- R6: In byte mode (`mode_byte_i`=1), `rsp_data_o[7:0]` comes from `adc_db_i[7:0]` of the first access, made with byte-select low. Chip-select and the strobe are then high for at least `GAP_CLKS` clocks. A second access follows with `adc_hben_o`=1, and its `adc_db_i[5:0]` become `rsp_data_o[13:8]`.
- R7: If busy does not complete its low-then-high cycle within `TMO_CLKS` clocks of chip-select falling, the lines are released and `rsp_valid_o` pulses with `rsp_err_o`=1 and `rsp_data_o`=0. No high-byte access is made.
- R8: `mode_byte_i` is sampled only when a request is accepted. Changing it during a transaction has no effect on that transaction.
- R9: `rsp_valid_o` is a single-cycle pulse. `req_rdy_o` is 0 while a transaction runs, and `req_i` is ignored while `req_rdy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request a conversion and read |
| req_rdy_o | output | 1 | Controller idle; a request is accepted |
| mode_byte_i | input | 1 | 1 = two-byte reads, 0 = 14-bit parallel read |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_err_o | output | 1 | Response is a timeout abort |
| rsp_data_o | output | 14 | Assembled sample |
| adc_cs_n_o | output | 1 | Converter chip-select, active low |
| adc_rd_n_o | output | 1 | Converter read strobe, active low |
| adc_hben_o | output | 1 | Converter high-byte select |
| adc_busy_n_i | input | 1 | Converter busy, low while converting |
| adc_db_i | input | 14 | Converter data lines |

## Verification
The assertions assume a converter that lowers busy only in response to a chip-select fall with byte-select low. They also assume it never lowers busy during a high-byte read. The bench's converter model keeps to this contract. It starts a conversion only while it is idle, and it waits for any aborted conversion to finish before the next request. The model also drives deliberate garbage on the data lines until the strobe has been low long enough. A controller that latches early therefore returns a wrong sample.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_ARM, ST_CONV, ST_LORD, ST_GAP, ST_HIRD, ST_DONE, ST_FAIL
    } rd_st_e;
endpackage

// File: rtl/adc_rd_cnt.sv
module adc_rd_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (en)  q <= q + W'(1);
    end
endmodule

// File: rtl/adc_rd_asm.sv
module adc_rd_asm #(
    parameter int DW   = 14,
    parameter int LO_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          cap_lo,
    input  logic          cap_full,
    input  logic          cap_hi,
    input  logic [DW-1:0] db,
    output logic [DW-1:0] data
);
    localparam int HI_W = DW - LO_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
        end else if (clr) begin
            data <= '0;
        end else if (cap_lo) begin
            data[LO_W-1:0] <= db[LO_W-1:0];
            if (cap_full) data[DW-1:LO_W] <= db[DW-1:LO_W];
        end else if (cap_hi) begin
            data[DW-1:LO_W] <= db[HI_W-1:0];
        end
    end

    // R6: the two byte captures never coincide
    assert_single_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap_lo, cap_hi}));
endmodule

// File: rtl/adc_rd_fsm.sv
module adc_rd_fsm
    import adc_rd_pkg::*;
#(
    parameter int RD_DLY   = 3,
    parameter int GAP_CLKS = 4,
    parameter int TMO_CLKS = 64,
    parameter int PH_W     = 3,
    parameter int TMO_W    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             mode_byte_i,
    input  logic             busy_n_i,
    input  logic [PH_W-1:0]  ph_cnt_i,
    input  logic [TMO_W-1:0] tmo_cnt_i,
    output logic             ph_clr_o,
    output logic             tmo_clr_o,
    output logic             tmo_en_o,
    output logic             accept_o,
    output logic             cap_lo_o,
    output logic             cap_full_o,
    output logic             cap_hi_o,
    output logic             cs_n_o,
    output logic             rd_n_o,
    output logic             hben_o,
    output logic             rsp_valid_o,
    output logic             rsp_err_o,
    output logic             req_rdy_o
);
    localparam logic [PH_W-1:0]  RD_LAST  = PH_W'(RD_DLY - 1);
    localparam logic [PH_W-1:0]  GAP_LAST = PH_W'(GAP_CLKS - 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CLKS - 1);

    rd_st_e st_q, st_d;
    logic   mode_q;
    logic   ph_done, tmo_hit;

    assign ph_done  = (ph_cnt_i == ((st_q == ST_GAP) ? GAP_LAST : RD_LAST));
    assign tmo_hit  = (tmo_cnt_i == TMO_LAST);
    assign accept_o = (st_q == ST_IDLE) && req_i;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (req_i) st_d = ST_ARM;
            ST_ARM:  if (!busy_n_i) st_d = ST_CONV;
                     else if (tmo_hit) st_d = ST_FAIL;
            ST_CONV: if (busy_n_i) st_d = ST_LORD;
                     else if (tmo_hit) st_d = ST_FAIL;
            ST_LORD: if (ph_done) st_d = mode_q ? ST_GAP : ST_DONE;
            ST_GAP:  if (ph_done) st_d = ST_HIRD;
            ST_HIRD: if (ph_done) st_d = ST_DONE;
            ST_DONE: st_d = ST_IDLE;
            ST_FAIL: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    assign ph_clr_o   = (st_d != st_q);
    assign tmo_clr_o  = (st_q == ST_IDLE);
    assign tmo_en_o   = (st_q == ST_ARM) || (st_q == ST_CONV);
    assign cap_lo_o   = (st_q == ST_LORD) && ph_done;
    assign cap_full_o = !mode_q;
    assign cap_hi_o   = (st_q == ST_HIRD) && ph_done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            mode_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (accept_o) mode_q <= mode_byte_i;
        end
    end

    // registered outputs, decoded from the next state so they never glitch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_o      <= 1'b1;
            rd_n_o      <= 1'b1;
            hben_o      <= 1'b0;
            rsp_valid_o <= 1'b0;
            rsp_err_o   <= 1'b0;
            req_rdy_o   <= 1'b1;
        end else begin
            cs_n_o      <= !(st_d inside {ST_ARM, ST_CONV, ST_LORD, ST_HIRD});
            rd_n_o      <= !(st_d inside {ST_ARM, ST_CONV, ST_LORD, ST_HIRD});
            hben_o      <= st_d inside {ST_GAP, ST_HIRD};
            rsp_valid_o <= st_d inside {ST_DONE, ST_FAIL};
            rsp_err_o   <= (st_d == ST_FAIL);
            req_rdy_o   <= (st_d == ST_IDLE);
        end
    end

    assert_start_lines_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ARM) |-> (!hben_o && !cs_n_o && !rd_n_o));
    assert_busy_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LORD && $past(st_q) == ST_CONV) |-> $past(busy_n_i));
    assert_gap_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HIRD && $past(st_q) == ST_GAP) |-> ($past(cs_n_o) && $past(rd_n_o)));
    assert_tmo_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ARM || st_q == ST_CONV) |-> (tmo_cnt_i <= TMO_LAST));
    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |=> $stable(mode_q));
    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o);
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
    parameter int DW       = 14,
    parameter int LO_W     = 8,
    parameter int RD_DLY   = 3,
    parameter int GAP_CLKS = 4,
    parameter int TMO_CLKS = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    output logic          req_rdy_o,
    input  logic          mode_byte_i,
    output logic          rsp_valid_o,
    output logic          rsp_err_o,
    output logic [DW-1:0] rsp_data_o,
    output logic          adc_cs_n_o,
    output logic          adc_rd_n_o,
    output logic          adc_hben_o,
    input  logic          adc_busy_n_i,
    input  logic [DW-1:0] adc_db_i
);
    localparam int PH_MAX = (RD_DLY > GAP_CLKS) ? RD_DLY : GAP_CLKS;
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int TMO_W  = $clog2(TMO_CLKS + 1);

    logic [PH_W-1:0]  ph_cnt;
    logic [TMO_W-1:0] tmo_cnt;
    logic ph_clr, tmo_clr, tmo_en, accept;
    logic cap_lo, cap_full, cap_hi;

    adc_rd_fsm #(
        .RD_DLY(RD_DLY), .GAP_CLKS(GAP_CLKS), .TMO_CLKS(TMO_CLKS),
        .PH_W(PH_W), .TMO_W(TMO_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_byte_i(mode_byte_i),
        .busy_n_i(adc_busy_n_i), .ph_cnt_i(ph_cnt), .tmo_cnt_i(tmo_cnt),
        .ph_clr_o(ph_clr), .tmo_clr_o(tmo_clr), .tmo_en_o(tmo_en),
        .accept_o(accept), .cap_lo_o(cap_lo), .cap_full_o(cap_full),
        .cap_hi_o(cap_hi), .cs_n_o(adc_cs_n_o), .rd_n_o(adc_rd_n_o),
        .hben_o(adc_hben_o), .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o),
        .req_rdy_o(req_rdy_o)
    );

    adc_rd_cnt #(.W(PH_W)) u_ph_cnt (
        .clk(clk), .rst_n(rst_n), .clr(ph_clr), .en(1'b1), .q(ph_cnt)
    );

    adc_rd_cnt #(.W(TMO_W)) u_tmo_cnt (
        .clk(clk), .rst_n(rst_n), .clr(tmo_clr), .en(tmo_en), .q(tmo_cnt)
    );

    adc_rd_asm #(.DW(DW), .LO_W(LO_W)) u_asm (
        .clk(clk), .rst_n(rst_n), .clr(accept), .cap_lo(cap_lo),
        .cap_full(cap_full), .cap_hi(cap_hi), .db(adc_db_i), .data(rsp_data_o)
    );
endmodule

// File: tb/adc_rd_ctrl_bench.sv
`timescale 1ns/1ps
module adc_rd_ctrl_bench;
    localparam int RD_DLY = 3;
    localparam int GAP_CLKS = 4;
    localparam int TMO_CLKS = 64;
    localparam int NV = 6;
    // {byte mode, conversion length (0 = busy never falls), sample, expect error}
    localparam logic [23:0] VEC [NV] = '{
        {1'b0, 8'd10,  14'h2A5C, 1'b0},
        {1'b1, 8'd10,  14'h1B3D, 1'b0},
        {1'b0, 8'd40,  14'h3FFF, 1'b0},
        {1'b1, 8'd1,   14'h0001, 1'b0},
        {1'b1, 8'd200, 14'h1234, 1'b1},
        {1'b0, 8'd0,   14'h0ABC, 1'b1}
    };

    logic clk = 0, rst_n = 0, req = 0, mode_byte = 0;
    logic req_rdy, rsp_valid, rsp_err, cs_n, rd_n, hben;
    logic [13:0] rsp_data, db;
    logic busy_n;
    int checks = 0, errors = 0;

    // converter model state
    logic m_mode = 0;
    int   m_conv = 10;
    logic [13:0] m_smp = '0;
    int m_left, m_lo_falls, m_hi_falls, m_gap_cnt, m_last_gap, m_rdcnt;
    logic m_cs_prev;

    always #2.5 clk = ~clk;

    adc_rd_ctrl #(.RD_DLY(RD_DLY), .GAP_CLKS(GAP_CLKS), .TMO_CLKS(TMO_CLKS)) u_adc_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_rdy_o(req_rdy),
        .mode_byte_i(mode_byte), .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err),
        .rsp_data_o(rsp_data), .adc_cs_n_o(cs_n), .adc_rd_n_o(rd_n),
        .adc_hben_o(hben), .adc_busy_n_i(busy_n), .adc_db_i(db)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_n <= 1'b1; m_left <= 0; m_lo_falls <= 0; m_hi_falls <= 0;
            m_gap_cnt <= 0; m_last_gap <= 0; m_rdcnt <= 0; m_cs_prev <= 1'b1;
        end else begin
            m_cs_prev <= cs_n;
            m_gap_cnt <= cs_n ? m_gap_cnt + 1 : 0;
            m_rdcnt   <= (!rd_n && busy_n) ? m_rdcnt + 1 : 0;
            if (m_cs_prev && !cs_n) begin
                m_last_gap <= m_gap_cnt;
                if (hben) m_hi_falls <= m_hi_falls + 1;
                else      m_lo_falls <= m_lo_falls + 1;
                if (!hben && busy_n && m_conv != 0) begin
                    busy_n <= 1'b0;
                    m_left <= m_conv;
                end
            end else if (!busy_n) begin
                m_left <= m_left - 1;
                if (m_left <= 1) busy_n <= 1'b1;
            end
        end
    end

    // data lines: garbage until the strobe has been low long enough with busy high
    always_comb begin
        db = 14'h2D2D;
        if (!rd_n && busy_n && m_rdcnt >= RD_DLY - 1) begin
            if (!m_mode)   db = m_smp;
            else if (hben) db = {8'hA5, m_smp[13:8]};
            else           db = {6'h2B, m_smp[7:0]};
        end
    end

    task automatic check(input bit ok, input string req_tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req_tag, act, exp);
        end
    endtask

    task automatic issue(input logic m);
        @(negedge clk); req = 1; mode_byte = m;
        @(negedge clk); req = 0;
    endtask

    task automatic wait_rsp(output bit got);
        got = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (rsp_valid) begin got = 1; break; end
        end
    endtask

    task automatic run_one(input logic m, input int conv, input logic [13:0] smp, input logic err);
        int lo0, hi0; bit got;
        while (!busy_n) @(negedge clk);
        m_mode = m; m_conv = conv; m_smp = smp;
        lo0 = m_lo_falls; hi0 = m_hi_falls;
        issue(m);
        wait_rsp(got);
        check(got, "R2 response seen", int'(got), 1);
        check(rsp_err == err, "R7 error flag", int'(rsp_err), int'(err));
        if (err)
            check(rsp_data == 0, "R7 aborted data", int'(rsp_data), 0);
        else if (!m)
            check(rsp_data == smp, "R5 R3 R4 parallel data", int'(rsp_data), int'(smp));
        else
            check(rsp_data == smp, "R6 R4 byte data", int'(rsp_data), int'(smp));
        check(m_lo_falls - lo0 == 1, "R2 one low-select start", m_lo_falls - lo0, 1);
        check(m_hi_falls - hi0 == ((m && !err) ? 1 : 0), "R6 R7 high access count",
              m_hi_falls - hi0, (m && !err) ? 1 : 0);
        if (m && !err)
            check(m_last_gap >= GAP_CLKS, "R6 gap length", m_last_gap, GAP_CLKS);
        @(negedge clk);
        check(!rsp_valid, "R9 pulse width", int'(rsp_valid), 0);
    endtask

    initial begin
        bit got; int lo0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cs_n && rd_n && !hben && !rsp_valid && !rsp_err && req_rdy, "R1 reset outputs",
              {cs_n, rd_n, hben, rsp_valid, rsp_err, req_rdy}, 6'b110001);
        rst_n = 1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++)
            run_one(VEC[v][23], int'(VEC[v][22:15]), VEC[v][14:1], VEC[v][0]);

        // R8: mode change mid-transaction is ignored
        while (!busy_n) @(negedge clk);
        m_mode = 0; m_conv = 12; m_smp = 14'h35C3; lo0 = m_hi_falls;
        issue(0);
        mode_byte = 1;
        wait_rsp(got);
        check(got && rsp_data == 14'h35C3, "R8 mode held", int'(rsp_data), 14'h35C3);
        check(m_hi_falls == lo0, "R8 no high access", m_hi_falls, lo0);
        mode_byte = 0;

        // R9: request ignored while not ready
        m_conv = 15; m_smp = 14'h0F0F; lo0 = m_lo_falls;
        issue(0);
        check(!req_rdy, "R9 ready low while running", int'(req_rdy), 0);
        req = 1; repeat (3) @(negedge clk); req = 0;
        wait_rsp(got);
        check(got && rsp_data == 14'h0F0F, "R9 data", int'(rsp_data), 14'h0F0F);
        repeat (20) @(negedge clk);
        check(m_lo_falls - lo0 == 1 && cs_n && req_rdy, "R9 late request dropped",
              m_lo_falls - lo0, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule